// File: doc/BRIEF.md
# SPI Register-Bank Slave with FIFO Data Port

This block is an SPI slave that gives an external host byte-wide access to a bank of 64 eight-bit registers. The interface uses clock mode 0 with 8-bit frames, most significant bit first. The host lowers chip select and sends an address byte. One or more data bytes follow in the same transaction. Bit 7 of the address byte picks the direction. Bits 6:1 select the register. Bit 0 carries no meaning and is ignored.

One address is not backed by storage. It is a data port into an external first-in first-out buffer:

- Every write data byte sent to that address becomes a push.
- Every read data frame from that address becomes a pop.
- A write while the buffer reports full is dropped and sets a sticky overflow flag.

A burst write sends every data byte to the same address. A burst read is clocked by repeating the address byte. A zero byte marks the final read frame.

The SPI pins are oversampled by the system clock, which must run at least four times the SCK rate. Inputs are sampled on SCK rising edges. MISO changes on SCK falling edges. MISO is disabled while chip select is high. Raising chip select at any point ends the transaction and discards any partial byte.

Top module: `spi_regbank_slave`

## Requirements
- R1: Frames are SPI mode 0, MSB first. In the first byte of a transaction, bit 7 = 1 means read and bit 7 = 0 means write, and bits 6:1 give the register address. Bit 0 is ignored, so an address byte with bit 0 set reaches the same register.
- R2: A write with one data byte stores that byte in the addressed register. A read returns the register contents on MISO during the second frame.
- R3: MISO shifts out 0x00 during the address frame and during every data frame of a write transaction.
- R4: In a burst write, every data byte goes to the one address. For a plain register, the last byte sent is the value kept.
- R5: In a burst read, each frame in which the host repeats the address byte is followed by a frame that returns the next value. A plain register returns the same contents every time. The frame in which the host sends 0x00 returns the last value. Any later frames in the transaction return 0x00 and have no side effect.
- R6: A read of the FIFO data address pulses fifo_pop for one clock once per read data frame, and returns fifo_rdata as it stood at that pop.
- R7: A write to the FIFO data address pulses fifo_push for one clock per data byte, with that byte on fifo_wdata.
- R8: A write to the FIFO data address while fifo_full is high gives no push and sets fifo_ovf. fifo_ovf then stays high until reset.
- R9: Raising chip select ends the transaction at once. A partially received byte is discarded and causes no write and no push.
- R10: miso_oe is low while chip select is high and high while it is low.
- R11: After reset, miso_oe, miso, fifo_push, fifo_pop and fifo_ovf are low, and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (idle low) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| fifo_full | input | 1 | External FIFO cannot accept a push |
| fifo_rdata | input | 8 | Head entry of the external FIFO (show-ahead) |
| fifo_push | output | 1 | One-cycle push strobe |
| fifo_wdata | output | 8 | Byte that accompanies fifo_push |
| fifo_pop | output | 1 | One-cycle pop strobe |
| fifo_ovf | output | 1 | Sticky flag: a push was dropped because the FIFO was full |

## Verification
A table of address and value pairs is written with single transfers and then read back with single transfers. Distinct values at scattered addresses show that address decode and shifting are independent of bit position. Further patterns each separate one behaviour:

- A repeated-address burst on a plain register tells burst sequencing apart from address increment.
- A zero-terminated burst on the FIFO port checks that the pop count equals the number of data frames. An extra trailing frame must add no pop.
- An over-long FIFO write checks that the overflow flag is set.
- An address byte with bit 0 set must reach the same register as one with bit 0 clear.
- A transaction cut off mid-byte must leave the target register untouched.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
   localparam int unsigned FRAME_W = 8;

   typedef logic [FRAME_W-1:0] frame_t;

   function automatic logic frame_is_read(input frame_t f);
      return f[FRAME_W-1];
   endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
   parameter int unsigned W       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= RST_VAL;
         else if (s == 0) stg[s] <= d;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter
   import spi_rb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sck_s,
   input  logic   cs_n_s,
   input  logic   mosi_s,
   input  logic   load,
   input  frame_t load_data,
   output logic   byte_done,
   output frame_t rx_byte,
   output logic   miso_q
);
   localparam int unsigned CNT_W = $clog2(FRAME_W);

   logic             sck_d;
   logic [CNT_W-1:0] bit_cnt;
   frame_t           tx_sr;
   logic             rise, fall;

   assign rise = sck_s & ~sck_d;
   assign fall = ~sck_s & sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         bit_cnt   <= '0;
         rx_byte   <= '0;
         tx_sr     <= '0;
         miso_q    <= 1'b0;
         byte_done <= 1'b0;
      end else begin
         sck_d     <= sck_s;
         byte_done <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            rx_byte <= '0;
            tx_sr   <= '0;
            miso_q  <= 1'b0;
         end else begin
            if (rise) begin
               rx_byte <= {rx_byte[FRAME_W-2:0], mosi_s};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(FRAME_W-1)) byte_done <= 1'b1;
            end
            if (load) begin
               tx_sr <= load_data;
            end else if (fall) begin
               miso_q <= tx_sr[FRAME_W-1];
               tx_sr  <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned NREGS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
   import spi_rb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FIFO_ADDR   = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sck,
   input  logic         cs_n,
   input  logic         mosi,
   output logic         miso,
   output logic         miso_oe,
   input  logic         fifo_full,
   input  logic [7:0]   fifo_rdata,
   output logic         fifo_push,
   output logic [7:0]   fifo_wdata,
   output logic         fifo_pop,
   output logic         fifo_ovf
);
   localparam int unsigned NREGS = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(FIFO_ADDR);

   if (ADDR_W + 2 != FRAME_W) begin : g_bad_aw
      $error("ADDR_W must leave one direction bit and one spare bit in a frame");
   end
   if (FIFO_ADDR >= NREGS) begin : g_bad_fa
      $error("FIFO_ADDR outside the register space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic   sck_s, cs_n_s, mosi_s;
   logic   byte_done, load;
   frame_t rx_byte, load_data;
   logic   first_q, is_rd_q, rd_end_q;
   logic [ADDR_W-1:0] addr_q, ld_addr;
   logic [7:0] reg_rdata;
   logic   data_frame, wr_frame, rd_more;

   spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sck, cs_n, mosi}),
      .q    ({sck_s, cs_n_s, mosi_s})
   );

   spi_rb_shifter u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (sck_s),
      .cs_n_s   (cs_n_s),
      .mosi_s   (mosi_s),
      .load     (load),
      .load_data(load_data),
      .byte_done(byte_done),
      .rx_byte  (rx_byte),
      .miso_q   (miso)
   );

   assign data_frame = byte_done & ~first_q;
   assign wr_frame   = data_frame & ~is_rd_q;
   assign rd_more    = data_frame & is_rd_q & ~rd_end_q & (rx_byte != '0);

   assign ld_addr   = first_q ? rx_byte[FRAME_W-2:1] : addr_q;
   assign load      = (byte_done & first_q & frame_is_read(rx_byte)) | rd_more;
   assign load_data = (ld_addr == PORT_ADDR) ? fifo_rdata : reg_rdata;
   assign fifo_pop  = load & (ld_addr == PORT_ADDR);

   assign fifo_push  = wr_frame & (addr_q == PORT_ADDR) & ~fifo_full;
   assign fifo_wdata = rx_byte;
   assign miso_oe    = ~cs_n_s;

   spi_rb_regs #(.ADDR_W(ADDR_W), .DATA_W(FRAME_W)) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_frame & (addr_q != PORT_ADDR)),
      .waddr(addr_q),
      .wdata(rx_byte),
      .raddr(ld_addr),
      .rdata(reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= 1'b1;
         is_rd_q  <= 1'b0;
         rd_end_q <= 1'b0;
         addr_q   <= '0;
         fifo_ovf <= 1'b0;
      end else begin
         if (cs_n_s) begin
            first_q  <= 1'b1;
            rd_end_q <= 1'b0;
         end else if (byte_done) begin
            if (first_q) begin
               first_q <= 1'b0;
               is_rd_q <= frame_is_read(rx_byte);
               addr_q  <= rx_byte[FRAME_W-2:1];
            end else if (is_rd_q && rx_byte == '0) begin
               rd_end_q <= 1'b1;
            end
         end
         if (wr_frame && addr_q == PORT_ADDR && fifo_full) fifo_ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic miso_oe,
   input logic fifo_full,
   input logic fifo_push,
   input logic fifo_pop,
   input logic fifo_ovf
);
   assert_oe_off_when_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

   assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !fifo_full);

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ovf |=> fifo_ovf);

   assert_pop_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !fifo_pop);

   assert_push_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |=> !fifo_push);

   assert_push_pop_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_push && fifo_pop));
endmodule

bind spi_regbank_slave spi_rb_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .miso_oe  (miso_oe),
   .fifo_full(fifo_full),
   .fifo_push(fifo_push),
   .fifo_pop (fifo_pop),
   .fifo_ovf (fifo_ovf)
);

// File: tb/spi_regbank_slave_tb.sv
module spi_regbank_slave_tb;
   localparam int HALF  = 6;
   localparam int FDEP  = 4;
   localparam logic [5:0] FA = 6'd9;
   localparam logic [13:0] VEC [6] = '{
      {6'd0,  8'hA5}, {6'd1,  8'h3C}, {6'd17, 8'hFF},
      {6'd31, 8'h01}, {6'd42, 8'h80}, {6'd63, 8'h96}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso, miso_oe, fifo_push, fifo_pop, fifo_ovf;
   logic [7:0] fifo_wdata;
   logic [7:0] fmem [FDEP];
   int fcnt = 0, pushes = 0, pops = 0;
   int checks = 0, fails = 0;
   logic done = 1'b0;
   logic fifo_full;
   logic [7:0] fifo_rdata;

   always #2.5 clk = ~clk;

   assign fifo_full  = (fcnt == FDEP);
   assign fifo_rdata = fmem[0];

   spi_regbank_slave u_dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .fifo_full(fifo_full),
      .fifo_rdata(fifo_rdata), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
      .fifo_pop(fifo_pop), .fifo_ovf(fifo_ovf)
   );

   always_ff @(posedge clk) begin
      if (fifo_push) begin
         pushes <= pushes + 1;
         if (fcnt < FDEP) begin
            fmem[fcnt] <= fifo_wdata;
            fcnt <= fcnt + 1;
         end
      end else if (fifo_pop) begin
         pops <= pops + 1;
         if (fcnt > 0) begin
            for (int k = 0; k < FDEP-1; k++) fmem[k] <= fmem[k+1];
            fmem[FDEP-1] <= 8'h00;
            fcnt <= fcnt - 1;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] o, input int nbits, output logic [7:0] i);
      i = '0;
      for (int b = 7; b > 7 - nbits; b--) begin
         mosi = o[b];
         wait_clk(HALF);
         sck = 1'b1;
         i[b] = miso;
         wait_clk(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic cs_low();
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic cs_high();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(3 * HALF);
   endtask

   task automatic wr1(input logic [5:0] a, input logic [7:0] d);
      logic [7:0] r;
      cs_low();
      xfer({1'b0, a, 1'b0}, 8, r);
      xfer(d, 8, r);
      check("R3 write frame miso", r, 0);
      cs_high();
   endtask

   task automatic rd1(input logic [5:0] a, output logic [7:0] d);
      logic [7:0] r;
      cs_low();
      check("R10 oe while selected", miso_oe, 1);
      xfer({1'b1, a, 1'b0}, 8, r);
      check("R3 address frame miso", r, 0);
      xfer(8'h00, 8, d);
      cs_high();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      for (int k = 0; k < FDEP; k++) fmem[k] = 8'h00;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R11 reset state, R10 disabled while deselected
      check("R11 miso_oe", miso_oe, 0);
      check("R11 miso", miso, 0);
      check("R11 fifo_ovf", fifo_ovf, 0);
      check("R11 strobes", {fifo_push, fifo_pop}, 0);
      rd1(6'd20, r);
      check("R11 register reset value", r, 0);

      // R2 table walk: single writes, then single reads
      for (int v = 0; v < 6; v++) wr1(VEC[v][13:8], VEC[v][7:0]);
      for (int v = 0; v < 6; v++) begin
         rd1(VEC[v][13:8], r);
         check("R2 single read", r, VEC[v][7:0]);
      end

      // R1 bit 0 of the address byte ignored
      cs_low();
      xfer({1'b0, 6'd5, 1'b1}, 8, r);
      xfer(8'h5A, 8, r);
      cs_high();
      rd1(6'd5, r);
      check("R1 bit0 ignored", r, 8'h5A);

      // R5 burst read of a plain register, zero byte ends, trailing frame 0
      cs_low();
      xfer({1'b1, 6'd17, 1'b0}, 8, r);
      xfer({1'b1, 6'd17, 1'b0}, 8, r);
      check("R5 burst frame 1", r, 8'hFF);
      xfer({1'b1, 6'd17, 1'b0}, 8, r);
      check("R5 burst frame 2", r, 8'hFF);
      xfer(8'h00, 8, r);
      check("R5 burst last frame", r, 8'hFF);
      xfer(8'h00, 8, r);
      check("R5 frame after end", r, 0);
      cs_high();

      // R7 R4 burst write to the FIFO port
      cs_low();
      xfer({1'b0, FA, 1'b0}, 8, r);
      xfer(8'h11, 8, r);
      xfer(8'h22, 8, r);
      xfer(8'h33, 8, r);
      cs_high();
      check("R7 push count", pushes, 3);
      check("R7 fifo level", fcnt, 3);
      check("R7 pushed data", {fmem[0], fmem[1], fmem[2]}, 24'h112233);

      // R6 burst read from the FIFO port
      cs_low();
      xfer({1'b1, FA, 1'b0}, 8, r);
      xfer({1'b1, FA, 1'b0}, 8, r);
      check("R6 pop data 1", r, 8'h11);
      xfer({1'b1, FA, 1'b0}, 8, r);
      check("R6 pop data 2", r, 8'h22);
      xfer(8'h00, 8, r);
      check("R6 pop data 3", r, 8'h33);
      xfer(8'h00, 8, r);
      check("R5 no data after end", r, 0);
      cs_high();
      check("R6 pop count", pops, 3);
      check("R8 no overflow yet", fifo_ovf, 0);

      // R8 overflow when writing past full
      cs_low();
      xfer({1'b0, FA, 1'b0}, 8, r);
      for (int k = 0; k < 6; k++) xfer(8'hC0 + 8'(k), 8, r);
      cs_high();
      check("R8 pushes capped", pushes, 3 + FDEP);
      check("R8 overflow flag", fifo_ovf, 1);
      wr1(6'd2, 8'h44);
      check("R8 overflow sticky", fifo_ovf, 1);

      // R4 burst write to a plain register keeps last byte
      cs_low();
      xfer({1'b0, 6'd40, 1'b0}, 8, r);
      xfer(8'hAA, 8, r);
      xfer(8'hBB, 8, r);
      xfer(8'hCC, 8, r);
      cs_high();
      rd1(6'd40, r);
      check("R4 burst write last byte", r, 8'hCC);

      // R9 abort mid-byte leaves register untouched
      cs_low();
      xfer({1'b0, 6'd1, 1'b0}, 8, r);
      xfer(8'hFF, 5, r);
      cs_high();
      check("R10 oe after deselect", miso_oe, 0);
      rd1(6'd1, r);
      check("R9 aborted write discarded", r, 8'h3C);

      finish_run();
   end
endmodule